// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month (with a century flag) and a two-digit year. A divider chain counts a slow oscillator clock enable (32768 enables per second by default) and steps the whole chain forward once per second. Month length and leap years are handled. The hour byte can run in 24-hour form or in 12-hour form with an AM/PM bit.

A host updates any of the seven bytes through a single-beat write channel. The channel is valid/ready, but `wr_ready` is tied high: every beat presented with `wr_valid` high is taken on that clock edge, and there is never back-pressure. A write to the seconds byte restarts the sub-second divider, which sets the phase of the 1 Hz square wave and of the next advance. `second_tick` pulses for one cycle in the first cycle that shows each new second, so alarm logic can sample the new time there.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. 59 goes to 00 and carries into the next field.
- R2: The time advances by one second after 2^DIV_W cycles with `tick_en` high. Cycles with `tick_en` low do not move the divider.
- R3: With hour bit 6 = 0 (24-hour mode), bits 5:0 hold BCD 00 to 23. 23 goes to 00 and carries one day.
- R4: With hour bit 6 = 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 1 to 12. The order is 11 to 12 with PM inverted, then 12 to 1 with PM kept. Going from 11 PM to 12 AM (0x52) carries one day.
- R5: On a day carry, the date goes back to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, February has 28, or 29 when the year is divisible by 4, and all other months have 31. Otherwise the date increments in BCD.
- R6: The month (bits 4:0) goes from 12 to 01 and carries into the year. The year goes from 99 to 00 and toggles month bit 7, the century flag.
- R7: Day of week (bits 2:0) increments on every day carry and wraps from 7 to 1, independent of the date.
- R8: A write updates one byte, chosen by `wr_addr`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. The stored values are masked with 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x9F and 0xFF. The written byte takes the write even in an advance cycle. The other bytes still advance, using carries computed from the old values. Address 7 is ignored. `wr_ready` is always 1.
- R9: A seconds write clears the divider and cancels any advance in that cycle. `sq_1hz` is the divider MSB. It is low for the first 2^(DIV_W-1) enables after the write and high for the second half.
- R10: `second_tick` is high for exactly one cycle. That cycle is the first one in which the outputs show the advanced time.
- R11: After reset the bytes read 00:00:00 in 24-hour mode, day of week 1, date 01, month 01 with the century flag at 0, and year 00. `sq_1hz` and `second_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oscillator clock enable, one per oscillator period |
| wr_valid | input | 1 | Host write beat present |
| wr_ready | output | 1 | Write accepted; constant 1 |
| wr_addr | input | 3 | Byte select for the write |
| wr_data | input | 8 | Write data (packed BCD) |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours with mode and PM bits |
| dow | output | 8 | Day of week 1 to 7 |
| date | output | 8 | Date, BCD |
| month | output | 8 | Month, BCD, bit 7 century |
| year | output | 8 | Year, BCD |
| sq_1hz | output | 1 | 1 Hz square wave, divider MSB |
| second_tick | output | 1 | One-cycle pulse per new second |

## Verification
The chain is started from preset times that sit a few seconds before each rollover: end of day in both hour modes, ends of 28-, 29-, 30- and 31-day months, and the 99-to-00 year wrap with the century flag set beforehand. These presets separate a wrong month length, leap rule, PM flip or midnight point from a correct one. Gapped `tick_en` patterns separate divider counting from plain cycle counting. A seconds write in the middle of a second shows where the square-wave phase restarts. A minutes write placed exactly in an advance cycle tests that the write wins for its own byte while the hour still takes the carry from the old minutes, and a write to address 7 must leave every byte unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DOW  = 3'd3,
    A_DATE = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_NONE = 3'd7
  } cal_addr_e;

  // packed BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + o) mod 4 == (2*t + o) mod 4
  function automatic logic leap_year(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  output logic sec_adv,
  output logic sq
);
  localparam logic [DIV_W-1:0] LAST = '1;

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  assign sec_adv = tick_en && !restart && (cnt == LAST);
  assign sq      = cnt[DIV_W-1];

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && !sq);

  // R2
  adv_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv |=> !sq);

endmodule

// File: rtl/cal_time.sv
module cal_time
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      wr_en,
  input  cal_addr_e wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic      day_carry
);
  logic       sec_wr, min_wr, hour_wr;
  logic       sec_wrap, min_wrap, min_step, hour_step, hour_wrap;
  logic [7:0] sec_nx, min_nx, hour_nx, hinc, h12inc;

  assign sec_wr  = wr_en && (wr_addr == A_SEC);
  assign min_wr  = wr_en && (wr_addr == A_MIN);
  assign hour_wr = wr_en && (wr_addr == A_HOUR);

  always_comb begin
    sec_wrap  = (sec == 8'h59);
    sec_nx    = sec_wrap ? 8'h00 : bcd_inc(sec);
    min_step  = adv && sec_wrap;
    min_wrap  = (min == 8'h59);
    min_nx    = min_wrap ? 8'h00 : bcd_inc(min);
    hour_step = min_step && min_wrap;
    hinc      = bcd_inc({2'b00, hour[5:0]});
    h12inc    = bcd_inc({3'b000, hour[4:0]});
    hour_wrap = 1'b0;
    if (hour[6]) begin
      if (hour[4:0] == 5'h12) begin
        hour_nx = {2'b01, hour[5], 5'h01};
      end else if (hour[4:0] == 5'h11) begin
        hour_nx   = {2'b01, ~hour[5], 5'h12};
        hour_wrap = hour[5];
      end else begin
        hour_nx = {2'b01, hour[5], h12inc[4:0]};
      end
    end else if (hour[5:0] == 6'h23) begin
      hour_nx   = 8'h00;
      hour_wrap = 1'b1;
    end else begin
      hour_nx = {2'b00, hinc[5:0]};
    end
    day_carry = hour_step && hour_wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else begin
      if (sec_wr)         sec  <= wr_data & 8'h7F;
      else if (adv)       sec  <= sec_nx;
      if (min_wr)         min  <= wr_data & 8'h7F;
      else if (min_step)  min  <= min_nx;
      if (hour_wr)        hour <= wr_data & 8'h7F;
      else if (hour_step) hour <= hour_nx;
    end
  end

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec == 8'h59 && !sec_wr) |=> (sec == 8'h00));

  // R3
  h24_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !hour[6] && !hour_wr) |=> (hour == 8'h00));

  // R4
  h12_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && hour[6] && !hour_wr) |=> (hour == 8'h52));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && hour[6] && hour[4:0] == 5'h11 && !hour_wr)
      |=> (hour[5] != $past(hour[5])));

endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       wr_en,
  input  cal_addr_e  wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic [2:0] dow_q;
  logic       dow_wr, date_wr, mon_wr, year_wr;
  logic       date_wrap, mon_step, mon_wrap, year_step, year_wrap;
  logic [5:0] last;
  logic [7:0] date_inc, mon_inc, month_nx, year_nx;

  assign dow_wr  = wr_en && (wr_addr == A_DOW);
  assign date_wr = wr_en && (wr_addr == A_DATE);
  assign mon_wr  = wr_en && (wr_addr == A_MON);
  assign year_wr = wr_en && (wr_addr == A_YEAR);

  always_comb begin
    last      = month_last(month[4:0], leap_year(year));
    date_wrap = (date[5:0] == last);
    date_inc  = bcd_inc(date);
    mon_step  = day_carry && date_wrap;
    mon_wrap  = (month[4:0] == 5'h12);
    mon_inc   = bcd_inc({3'b000, month[4:0]});
    year_step = mon_step && mon_wrap;
    year_wrap = (year == 8'h99);
    year_nx   = year_wrap ? 8'h00 : bcd_inc(year);
    month_nx  = {month[7] ^ (year_step && year_wrap), 2'b00,
                 mon_wrap ? 5'h01 : mon_inc[4:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q <= 3'd1;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (dow_wr)         dow_q <= wr_data[2:0];
      else if (day_carry) dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (date_wr)        date  <= wr_data & 8'h3F;
      else if (day_carry) date  <= date_wrap ? 8'h01 : date_inc;
      if (mon_wr)         month <= wr_data & 8'h9F;
      else if (mon_step)  month <= month_nx;
      if (year_wr)        year  <= wr_data;
      else if (year_step) year  <= year_nx;
    end
  end

  assign dow = {5'b00000, dow_q};

  // R7
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && dow_q == 3'd7 && !dow_wr) |=> (dow_q == 3'd1));

  // R5
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_step && !date_wr) |=> (date == 8'h01));

  // R6
  century_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && year == 8'h99 && !mon_wr) |=> (month[7] != $past(month[7])));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       sq_1hz,
  output logic       second_tick
);
  cal_addr_e addr_e;
  logic      wr_en, restart, sec_adv, day_carry;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;
  assign addr_e   = cal_addr_e'(wr_addr);
  assign restart  = wr_en && (addr_e == A_SEC);

  cal_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .sec_adv(sec_adv), .sq(sq_1hz)
  );

  cal_time u_time (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv), .wr_en(wr_en), .wr_addr(addr_e),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .day_carry(day_carry)
  );

  cal_date u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .wr_en(wr_en),
    .wr_addr(addr_e), .wr_data(wr_data), .dow(dow), .date(date),
    .month(month), .year(year)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) second_tick <= 1'b0;
    else        second_tick <= sec_adv;
  end

  // R10
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_tick |=> !second_tick);

endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam int DW   = 4;
  localparam int DMAX = (1 << DW) - 1;
  localparam int HALF = 1 << (DW - 1);

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, sq_1hz, second_tick;
  logic [7:0] sec, min, hour, dow, date, month, year;

  always #4 clk = ~clk;

  bcd_calendar #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .sec(sec),
    .min(min), .hour(hour), .dow(dow), .date(date), .month(month),
    .year(year), .sq_1hz(sq_1hz), .second_tick(second_tick)
  );

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_div, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year;
  bit m_h12, m_pm, m_cent, m_tick;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_reset();
    m_div = 0; m_sec = 0; m_min = 0; m_hr = 0; m_h12 = 0; m_pm = 0;
    m_dow = 1; m_date = 1; m_mon = 1; m_cent = 0; m_year = 0; m_tick = 0;
  endtask

  task automatic m_day();
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_date >= days_in(m_mon, m_year)) begin
      m_date = 1;
      if (m_mon == 12) begin
        m_mon = 1;
        if (m_year == 99) begin m_year = 0; m_cent = ~m_cent; end
        else m_year++;
      end else m_mon++;
    end else m_date++;
  endtask

  task automatic m_hour();
    if (m_h12) begin
      if (m_hr == 11) begin
        m_pm = ~m_pm; m_hr = 12;
        if (!m_pm) m_day();
      end else if (m_hr == 12) m_hr = 1;
      else m_hr++;
    end else if (m_hr == 23) begin m_hr = 0; m_day(); end
    else m_hr++;
  endtask

  task automatic m_second();
    if (m_sec == 59) begin
      m_sec = 0;
      if (m_min == 59) begin m_min = 0; m_hour(); end
      else m_min++;
    end else m_sec++;
  endtask

  task automatic m_write(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] h;
    case (a)
      3'd0: m_sec = from_bcd(d & 8'h7F);
      3'd1: m_min = from_bcd(d & 8'h7F);
      3'd2: begin
        h = d & 8'h7F; m_h12 = h[6];
        if (h[6]) begin m_pm = h[5]; m_hr = from_bcd({3'b000, h[4:0]}); end
        else m_hr = from_bcd({2'b00, h[5:0]});
      end
      3'd3: m_dow = int'(d[2:0]);
      3'd4: m_date = from_bcd(d & 8'h3F);
      3'd5: begin m_cent = d[7]; m_mon = from_bcd({3'b000, d[4:0]}); end
      3'd6: m_year = from_bcd(d);
      default: ; // R8: address 7 has no effect
    endcase
  endtask

  always @(posedge clk) begin
    bit wsec, adv;
    if (!rst_n) m_reset();
    else begin
      wsec = wr_valid && (wr_addr == 3'd0);
      adv  = tick_en && !wsec && (m_div == DMAX);
      if (wsec) m_div = 0;
      else if (tick_en) m_div = (m_div + 1) % (DMAX + 1);
      m_tick = adv;
      if (adv) m_second();
      if (wr_valid) m_write(wr_addr, wr_data);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_hour();
    if (m_h12) return {2'b01, m_pm, to_bcd(m_hr)[4:0]};
    return to_bcd(m_hr);
  endfunction

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "sec", sec, to_bcd(m_sec));
      chk("R1", "min", min, to_bcd(m_min));
      chk(m_h12 ? "R4" : "R3", "hour", hour, exp_hour());
      chk("R7", "dow", dow, 8'(m_dow));
      chk("R5", "date", date, to_bcd(m_date));
      chk("R6", "month", month, {m_cent, 2'b00, to_bcd(m_mon)[4:0]});
      chk("R6", "year", year, to_bcd(m_year));
      chk("R9", "sq_1hz", {7'd0, sq_1hz}, {7'd0, m_div >= HALF});
      chk("R10", "second_tick", {7'd0, second_tick}, {7'd0, m_tick});
      chk("R8", "wr_ready", {7'd0, wr_ready}, 8'h01);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_secs(input int n);
    repeat (n * (DMAX + 1)) @(negedge clk);
  endtask

  task automatic preset(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                        input logic [7:0] dw, input logic [7:0] dt,
                        input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "reset sec", sec, 8'h00);
    chk("R11", "reset hour", hour, 8'h00);
    chk("R11", "reset dow", dow, 8'h01);
    chk("R11", "reset date", date, 8'h01);
    chk("R11", "reset month", month, 8'h01);
    chk("R11", "reset year", year, 8'h00);
    chk("R11", "reset tick", {7'd0, second_tick}, 8'h00);
    // R1 R2: free run
    tick_en = 1'b1;
    run_secs(3);
    // R2: gapped enables
    for (int i = 0; i < 80; i++) begin
      tick_en = i[0];
      @(negedge clk);
    end
    tick_en = 1'b1;
    // R3 R5 R7: 23:59:55 Feb 28, year 23, dow 7
    preset(8'h55, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    run_secs(7);
    // R5: leap year Feb 28 -> 29 -> Mar 1
    preset(8'h58, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    run_secs(3);
    preset(8'h58, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    run_secs(3);
    // R5: 30-day month
    preset(8'h58, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    run_secs(3);
    // R6: year wrap with century already set
    preset(8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h92, 8'h99);
    run_secs(3);
    // R4: 11 PM -> 12 AM, 11 AM -> 12 PM, 12 PM -> 1 PM
    preset(8'h58, 8'h59, 8'h71, 8'h05, 8'h15, 8'h06, 8'h30);
    run_secs(3);
    wr(3'd0, 8'h58); wr(3'd1, 8'h59); wr(3'd2, 8'h51);
    run_secs(3);
    wr(3'd0, 8'h58); wr(3'd1, 8'h59); wr(3'd2, 8'h72);
    run_secs(3);
    // R9: seconds write mid-second restarts the square-wave phase
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (HALF - 1) @(negedge clk);
    chk("R9", "sq low before half", {7'd0, sq_1hz}, 8'h00);
    @(negedge clk);
    chk("R9", "sq high at half", {7'd0, sq_1hz}, 8'h01);
    run_secs(2);
    // R8: minutes write in the advance cycle, hour takes old carry
    wr(3'd2, 8'h05); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    while (m_div != DMAX) @(negedge clk);
    wr(3'd1, 8'h30);
    chk("R8", "write wins minutes", min, 8'h30);
    chk("R8", "hour carried", hour, 8'h06);
    chk("R8", "sec advanced", sec, 8'h00);
    // R8: address 7 ignored
    wr(3'd7, 8'h44);
    chk("R8", "addr7 sec", sec, 8'h00);
    chk("R8", "addr7 year", year, to_bcd(m_year));
    run_secs(2);
    finish_run();
  end

endmodule